// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table Controller

This block sits inside a device endpoint and turns the device's interrupt requests into message writes. It keeps a table with one entry per vector: a 64-bit message address, a 32-bit message payload and a per-vector mask bit. It also keeps a pending bit for every vector and two function-level control bits, enable and mask-all. Software reaches all of this through a 32-bit register port that also takes 8-byte accesses. The device raises one vector per cycle. For an unmasked vector the block presents the entry's address and payload on a valid/ready message output. For a masked vector it records a pending bit instead.

A vector is masked when the function is disabled, when mask-all is set, or when its own mask bit is set. When a vector leaves the masked state with its pending bit set, the bit is cleared and exactly one message goes out. This applies to a per-vector unmask, to enabling the function and to clearing mask-all. When several vectors are ready at once, they leave one per handshake, lowest index first. Requests for vectors outside the table, or for vectors the device has not declared in use, are discarded.

Top module: `msgint_ctrl`

## Requirements
- R1: A vector is masked when enable is 0, or mask-all is 1, or its entry mask bit is 1. No message is ever presented for a masked vector.
- R2: An accepted request on a masked vector presents no message and sets that vector's pending bit.
- R3: When a vector goes from masked to unmasked with its pending bit set, the bit clears and exactly one message is sent for it. An unmask with no pending bit sends nothing.
- R4: The pending region starts at 0x800. Vector v is bit v%8 of byte v/8, so the 32-bit word at 0x800 holds vector v in bit v for v below 32.
- R5: Writes into the pending region have no effect.
- R6: The control word at 0x000 holds enable in bit 15 and mask-all in bit 14, and only these two bits are writable. Bits 10:0 read as the vector count minus one. All other bits read 0.
- R7: Enabling the function or clearing mask-all re-evaluates every vector, so every pending vector that becomes unmasked is sent once.
- R8: Reset clears enable, mask-all, every pending bit and every table field, and sets every entry's mask bit.
- R9: A request whose vector index is at or above the vector count, or whose vector is not marked in use, is dropped. It sets no pending bit and sends no message.
- R10: Accesses are 4 or 8 bytes. An aligned 8-byte access carries the word at the address in bits 31:0 and the word at address+4 in bits 63:32. A 4-byte write leaves address+4 untouched.
- R11: Entry v starts at 0x400+16*v. Offset 0 holds address bits 31:0, offset 4 address bits 63:32, offset 8 the payload, and offset 12 the mask bit in bit 0, with the other bits reading 0.
- R12: Messages leave one per valid/ready handshake, lowest ready vector index first. A presented message holds while ready is low and no register write or request arrives.
- R13: A request on an unmasked vector presents a message carrying that entry's 64-bit address and payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_valid | input | 1 | Register access strobe |
| csr_write | input | 1 | 1 = write, 0 = read |
| csr_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| csr_addr | input | 12 | Byte address of the access |
| csr_wdata | input | 64 | Write data; upper word used only for 8-byte writes |
| csr_rdata | output | 64 | Read data for csr_addr (lower) and csr_addr+4 (upper) |
| vec_used | input | NUM_VEC | Per-vector in-use flags from the device |
| irq_valid | input | 1 | Interrupt request strobe |
| irq_vec | input | 6 | Vector index of the request |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Message accepted by the bus side |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message payload |

## Verification
The main function is tried under four patterns. The first is a request on an unmasked vector, which separates direct delivery from queuing. The second is a request on a per-vector-masked vector followed by an unmask, which shows that the replay happens once and only when a bit is pending. The third is a batch of requests under mask-all, released by one control write while the bus stalls, which checks re-evaluation of all vectors and lowest-first ordering. The fourth is a request under a disabled function. Out-of-range and unused-vector requests, pending-region writes and partial writes of 8-byte words show that ignored traffic leaves the visible state unchanged.

// File: rtl/msgint_pkg.sv
package msgint_pkg;
    localparam int IDX_W  = 6;
    localparam int ADDR_W = 12;

    typedef enum logic [1:0] {
        RGN_CTRL = 2'd0,
        RGN_TBL  = 2'd1,
        RGN_PEND = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

    typedef struct packed {
        logic [31:0] adr_lo;
        logic [31:0] adr_hi;
        logic [31:0] payload;
        logic        vmask;
    } vec_entry_t;

    localparam vec_entry_t ENTRY_RST = '{adr_lo: 32'd0, adr_hi: 32'd0,
                                         payload: 32'd0, vmask: 1'b1};
endpackage

// File: rtl/msgint_pick.sv
module msgint_pick #(
    parameter int NUM_VEC = 8
) (
    input  logic [NUM_VEC-1:0]            req,
    output logic                          any,
    output logic [msgint_pkg::IDX_W-1:0]  idx,
    output logic [NUM_VEC-1:0]            onehot
);
    import msgint_pkg::*;

    always_comb begin
        any    = |req;
        idx    = '0;
        onehot = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx       = IDX_W'(i);
                onehot    = '0;
                onehot[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/msgint_pend.sv
module msgint_pend #(
    parameter int NUM_VEC = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_fire,
    input  logic [msgint_pkg::IDX_W-1:0]  req_idx,
    input  logic                          take,
    input  logic [NUM_VEC-1:0]            take_oh,
    input  logic [NUM_VEC-1:0]            eff_q,
    input  logic [NUM_VEC-1:0]            eff_d,
    output logic [NUM_VEC-1:0]            pend_q,
    output logic [NUM_VEC-1:0]            send_q
);
    localparam logic [NUM_VEC-1:0] VEC_ONE = NUM_VEC'(1);

    typedef struct packed {
        logic [NUM_VEC-1:0] pend;
        logic [NUM_VEC-1:0] send;
    } pstate_t;

    pstate_t            ps_d, ps_q;
    logic [NUM_VEC-1:0] want;
    logic [NUM_VEC-1:0] req_oh;

    // A vector is either waiting while masked or queued while unmasked;
    // the next-cycle mask decides which, so any unmask edge turns a
    // pending bit into exactly one queued send.
    always_comb begin
        req_oh = req_fire ? (VEC_ONE << req_idx) : '0;
        want   = ps_q.pend | ps_q.send;
        if (take) begin
            want = want & ~take_oh;
        end
        want      = want | req_oh;
        ps_d.pend = want & eff_d;
        ps_d.send = want & ~eff_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    assign pend_q = ps_q.pend;
    assign send_q = ps_q.send;

    assert_masked_req_pends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_fire && ((eff_d & req_oh) != '0) |=> ((pend_q & $past(req_oh)) != '0));

    assert_pend_only_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~eff_q) == '0);

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_replay
        assert_unmask_replays_R3: assert property (@(posedge clk) disable iff (!rst_n)
            pend_q[g] && !eff_d[g] |=> send_q[g] && !pend_q[g]);
    end
endmodule

// File: rtl/msgint_ctrl.sv
module msgint_ctrl #(
    parameter int NUM_VEC = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          csr_valid,
    input  logic                          csr_write,
    input  logic                          csr_wide,
    input  logic [msgint_pkg::ADDR_W-1:0] csr_addr,
    input  logic [63:0]                   csr_wdata,
    output logic [63:0]                   csr_rdata,
    input  logic [NUM_VEC-1:0]            vec_used,
    input  logic                          irq_valid,
    input  logic [msgint_pkg::IDX_W-1:0]  irq_vec,
    output logic                          msg_valid,
    input  logic                          msg_ready,
    output logic [63:0]                   msg_addr,
    output logic [31:0]                   msg_data
);
    import msgint_pkg::*;

    localparam logic [10:0] SIZE_FIELD = 11'(NUM_VEC - 1);

    typedef struct packed {
        logic                         en;
        logic                         mall;
        vec_entry_t [NUM_VEC-1:0]     tbl;
    } tstate_t;

    tstate_t              st_d, st_q;
    logic [NUM_VEC-1:0]   eff_q, eff_d;
    logic [NUM_VEC-1:0]   pend_q, send_q;
    logic [NUM_VEC-1:0]   pick_oh;
    logic [IDX_W-1:0]     pick_idx;
    logic                 pick_any;
    logic                 irq_fire;
    logic                 take;
    logic [ADDR_W-1:0]    wa_lo, wa_hi;
    logic [63:0]          used_ext;
    logic                 unused_addr;

    function automatic logic [NUM_VEC-1:0] eff_of(tstate_t s);
        logic [NUM_VEC-1:0] m;
        for (int i = 0; i < NUM_VEC; i++) begin
            m[i] = !s.en || s.mall || s.tbl[i].vmask;
        end
        return m;
    endfunction

    function automatic tstate_t put_word(tstate_t s, logic [ADDR_W-1:0] wa,
                                         logic [31:0] wv);
        tstate_t r = s;
        case (region_e'(wa[11:10]))
            RGN_CTRL: if (wa[9:2] == 8'd0) begin
                r.en   = wv[15];
                r.mall = wv[14];
            end
            RGN_TBL: for (int i = 0; i < NUM_VEC; i++) begin
                if (wa[9:4] == IDX_W'(i)) begin
                    case (wa[3:2])
                        2'd0:    r.tbl[i].adr_lo  = wv;
                        2'd1:    r.tbl[i].adr_hi  = wv;
                        2'd2:    r.tbl[i].payload = wv;
                        default: r.tbl[i].vmask   = wv[0];
                    endcase
                end
            end
            default: ;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] get_word(tstate_t s, logic [NUM_VEC-1:0] pb,
                                             logic [ADDR_W-1:0] wa);
        logic [31:0] w = '0;
        logic [63:0] pb_ext = 64'(pb);
        case (region_e'(wa[11:10]))
            RGN_CTRL: if (wa[9:2] == 8'd0) begin
                w = {16'd0, s.en, s.mall, 3'd0, SIZE_FIELD};
            end
            RGN_TBL: for (int i = 0; i < NUM_VEC; i++) begin
                if (wa[9:4] == IDX_W'(i)) begin
                    case (wa[3:2])
                        2'd0:    w = s.tbl[i].adr_lo;
                        2'd1:    w = s.tbl[i].adr_hi;
                        2'd2:    w = s.tbl[i].payload;
                        default: w = {31'd0, s.tbl[i].vmask};
                    endcase
                end
            end
            RGN_PEND: if (wa[9:3] == 7'd0) begin
                w = wa[2] ? pb_ext[63:32] : pb_ext[31:0];
            end
            default: ;
        endcase
        return w;
    endfunction

    assign wa_lo       = csr_addr;
    assign wa_hi       = csr_addr | ADDR_W'(4);
    assign unused_addr = ^csr_addr[1:0];
    assign used_ext    = 64'(vec_used);

    always_comb begin
        st_d = st_q;
        if (csr_valid && csr_write) begin
            st_d = put_word(st_d, wa_lo, csr_wdata[31:0]);
            if (csr_wide) begin
                st_d = put_word(st_d, wa_hi, csr_wdata[63:32]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.en   <= 1'b0;
            st_q.mall <= 1'b0;
            for (int i = 0; i < NUM_VEC; i++) begin
                st_q.tbl[i] <= ENTRY_RST;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign eff_q     = eff_of(st_q);
    assign eff_d     = eff_of(st_d);
    assign irq_fire  = irq_valid && (int'(irq_vec) < NUM_VEC) && used_ext[irq_vec];
    assign csr_rdata = {get_word(st_q, pend_q, wa_hi), get_word(st_q, pend_q, wa_lo)};

    msgint_pend #(.NUM_VEC(NUM_VEC)) pend_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_fire (irq_fire),
        .req_idx  (irq_vec),
        .take     (take),
        .take_oh  (pick_oh),
        .eff_q    (eff_q),
        .eff_d    (eff_d),
        .pend_q   (pend_q),
        .send_q   (send_q)
    );

    msgint_pick #(.NUM_VEC(NUM_VEC)) pick_i (
        .req    (send_q),
        .any    (pick_any),
        .idx    (pick_idx),
        .onehot (pick_oh)
    );

    always_comb begin
        msg_addr = '0;
        msg_data = '0;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (pick_oh[i]) begin
                msg_addr = {st_q.tbl[i].adr_hi, st_q.tbl[i].adr_lo};
                msg_data = st_q.tbl[i].payload;
            end
        end
    end

    assign msg_valid = pick_any;
    assign take      = msg_valid && msg_ready;

    assert_msg_unmasked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ((eff_q & pick_oh) == '0));

    assert_pend_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        csr_valid && csr_write && (csr_addr[11:10] == 2'd2) && !irq_valid
        |=> $stable(pend_q));

    assert_drop_no_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid && !irq_fire && !(csr_valid && csr_write) |=> $stable(pend_q));

    assert_lowest_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ($countones(pick_oh) == 1) &&
                      ((send_q & (pick_oh - NUM_VEC'(1))) == '0) &&
                      (int'(pick_idx) < NUM_VEC));

    assert_hold_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready && !(csr_valid && csr_write) && !irq_valid
        |=> msg_valid && $stable(msg_data) && $stable(msg_addr));
endmodule

// File: tb/msgint_ctrl_tb_top.sv
`timescale 1ns/1ps
module msgint_ctrl_tb_top;
    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_valid = 1'b0, csr_write = 1'b0, csr_wide = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic [NV-1:0] vec_used = 8'hBF;
    logic        irq_valid = 1'b0;
    logic [5:0]  irq_vec = '0;
    logic        msg_valid, msg_ready = 1'b1;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;

    int n_chk = 0, n_fail = 0, n_msg = 0;
    logic [31:0] log_data [0:63];
    logic [63:0] log_addr [0:63];

    always #10 clk = ~clk;

    msgint_ctrl #(.NUM_VEC(NV)) dut_i (
        .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_write(csr_write),
        .csr_wide(csr_wide), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .vec_used(vec_used), .irq_valid(irq_valid),
        .irq_vec(irq_vec), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    always @(posedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            if (n_msg < 64) begin
                log_data[n_msg] = msg_data;
                log_addr[n_msg] = msg_addr;
            end
            n_msg = n_msg + 1;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic wide);
        @(negedge clk);
        csr_valid = 1'b1; csr_write = 1'b1; csr_addr = a; csr_wdata = d; csr_wide = wide;
        @(negedge clk);
        csr_valid = 1'b0; csr_write = 1'b0; csr_wide = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d);
        @(negedge clk);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    task automatic irq(input logic [5:0] v);
        @(negedge clk);
        irq_valid = 1'b1; irq_vec = v;
        @(negedge clk);
        irq_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [11:0] ent(input int v, input int off);
        return 12'h400 + 12'(16 * v + off);
    endfunction

    task automatic t_reset;
        logic [63:0] d;
        rd(12'h000, d);
        check("R8 R6 control after reset", d[31:0], 64'h7);
        rd(ent(2, 8), d);
        check("R8 R11 entry2 payload/mask after reset", d, {32'h1, 32'h0});
        rd(ent(5, 0), d);
        check("R8 entry5 address after reset", d, 64'h0);
        rd(12'h800, d);
        check("R8 pending after reset", d, 64'h0);
        check("R8 no message after reset", {63'd0, msg_valid}, 64'h0);
    endtask

    task automatic t_program_and_pend;
        logic [63:0] d;
        int base;
        for (int v = 0; v < NV; v++) begin
            wr(ent(v, 0), {(v == 3) ? 32'h0000_00A5 : 32'h1, 32'hFEE0_0000 + 32'(16 * v)}, 1'b1);
            wr(ent(v, 8), {32'h1, 32'h100 + 32'(v)}, 1'b1);
        end
        wr(12'h000, 64'h8000, 1'b0);
        base = n_msg;
        irq(6'd3);
        idle(2);
        rd(12'h800, d);
        check("R2 R4 masked request sets byte0 bit3", d[31:0], 64'h08);
        check("R2 masked request sends nothing", 64'(n_msg - base), 64'd0);
        wr(12'h800, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        rd(12'h800, d);
        check("R5 pending write ignored", d, 64'h08);
    endtask

    task automatic t_unmask_replay;
        logic [63:0] d;
        int base;
        base = n_msg;
        wr(ent(3, 12), 64'h0, 1'b0);
        idle(3);
        check("R3 unmask with pending sends one", 64'(n_msg - base), 64'd1);
        check("R3 replayed payload", 64'(log_data[base]), 64'h103);
        rd(12'h800, d);
        check("R3 pending cleared on replay", d, 64'h0);
        base = n_msg;
        wr(ent(3, 12), 64'h1, 1'b0);
        wr(ent(3, 12), 64'h0, 1'b0);
        idle(3);
        check("R3 unmask without pending sends none", 64'(n_msg - base), 64'd0);
    endtask

    task automatic t_direct;
        int base;
        base = n_msg;
        irq(6'd3);
        idle(3);
        check("R13 unmasked request sends one", 64'(n_msg - base), 64'd1);
        check("R13 message payload", 64'(log_data[base]), 64'h103);
        check("R13 message address", log_addr[base], 64'h0000_00A5_FEE0_0030);
    endtask

    task automatic t_maskall_order;
        logic [63:0] d;
        int base;
        wr(12'h000, 64'hC000, 1'b0);
        wr(ent(1, 12), 64'h0, 1'b0);
        wr(ent(2, 12), 64'h0, 1'b0);
        wr(ent(5, 12), 64'h0, 1'b0);
        msg_ready = 1'b0;
        base = n_msg;
        irq(6'd5);
        irq(6'd1);
        irq(6'd2);
        idle(1);
        rd(12'h800, d);
        check("R7 R4 mask-all collects pending", d[31:0], 64'h26);
        check("R1 mask-all blocks delivery", {63'd0, msg_valid}, 64'h0);
        wr(12'h000, 64'h8000, 1'b0);
        idle(1);
        check("R7 release presents message", {63'd0, msg_valid}, 64'h1);
        check("R12 lowest vector first", 64'(msg_data), 64'h101);
        idle(3);
        check("R12 message held under stall", 64'(msg_data), 64'h101);
        msg_ready = 1'b1;
        idle(6);
        check("R7 all pending replayed once", 64'(n_msg - base), 64'd3);
        check("R12 order second", 64'(log_data[base + 1]), 64'h102);
        check("R12 order third", 64'(log_data[base + 2]), 64'h105);
        rd(12'h800, d);
        check("R7 pending empty after release", d, 64'h0);
    endtask

    task automatic t_drop;
        logic [63:0] d;
        int base;
        wr(12'h000, 64'hC000, 1'b0);
        base = n_msg;
        irq(6'd6);
        irq(6'd9);
        irq(6'd63);
        rd(12'h800, d);
        check("R9 dropped requests leave pending clear", d, 64'h0);
        wr(12'h000, 64'h8000, 1'b0);
        wr(ent(6, 12), 64'h0, 1'b0);
        irq(6'd6);
        idle(3);
        check("R9 dropped requests send nothing", 64'(n_msg - base), 64'd0);
    endtask

    task automatic t_disabled;
        logic [63:0] d;
        int base;
        wr(12'h000, 64'h0, 1'b0);
        base = n_msg;
        irq(6'd1);
        idle(1);
        rd(12'h800, d);
        check("R1 disabled function pends", d, 64'h02);
        check("R1 disabled function sends nothing", 64'(n_msg - base), 64'd0);
        wr(12'h000, 64'h8000, 1'b0);
        idle(3);
        check("R7 enable replays pending", 64'(n_msg - base), 64'd1);
        check("R7 enable replay payload", 64'(log_data[base]), 64'h101);
    endtask

    task automatic t_wide_and_ctrl;
        logic [63:0] d;
        rd(ent(1, 0), d);
        check("R10 R11 wide address read", d, {32'h1, 32'hFEE0_0010});
        wr(ent(1, 8), {32'h0, 32'h55}, 1'b1);
        rd(ent(1, 8), d);
        check("R10 wide payload/control write", d, {32'h0, 32'h55});
        wr(ent(1, 8), {32'h1, 32'h77}, 1'b0);
        rd(ent(1, 8), d);
        check("R10 narrow write leaves next word", d, {32'h0, 32'h77});
        wr(12'h000, 64'hFFFF_FFFF, 1'b0);
        rd(12'h000, d);
        check("R6 only enable and mask-all writable", d[31:0], 64'hC007);
        wr(12'h000, 64'h8000, 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program_and_pend();
        t_unmask_replay();
        t_direct();
        t_maskall_order();
        t_drop();
        t_disabled();
        t_wide_and_ctrl();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule